// File: doc/BRIEF.md
# Register Key Guard

The block guards a region of control registers behind a two-word write key. It watches 32-bit writes aimed at a single key register and keeps a sealed or open state. While the region is sealed, reads of the guarded registers return zero and writes to them are dropped. Opening the region takes the two key words written back to back to the key register. One all-ones word seals it again. A zero word throws away a half-entered key.

The sequencer has three states. `ST_SEALED` is the reset state, with no progress. `ST_ARMED` means the first key word has been seen. `ST_OPEN` means the region is accessible. The named transitions are:
- arm: `ST_SEALED` to `ST_ARMED` on the first word.
- rearm: `ST_ARMED` to `ST_ARMED` on the first word again.
- open: `ST_ARMED` to `ST_OPEN` on the second word.
- drop: `ST_ARMED` to `ST_SEALED` on any other key word, zero included.
- seal: `ST_OPEN` to `ST_SEALED` on the all-ones word.

Every other case holds the current state. A cycle without a key-register write never moves the state.

Top module: `register_key_guard`

## Requirements
- R1: After reset, `unlocked` is 0 and no partial key progress remains. Asserting reset while open returns the block to sealed.
- R2: While sealed, a key write of 0x5F554E4C followed by a key write of 0x4F434B5F sets `unlocked` to 1 on the clock edge that samples the second write.
- R3: After the first word, a key write of any value other than 0x4F434B5F discards the progress. If that value is 0x5F554E4C, it counts as a fresh first word.
- R4: A key write of 0x00000000 after the first word clears the progress, so a following 0x4F434B5F does not open the region.
- R5: Cycles with no key write between the two key words, including writes to the guarded registers, do not break the sequence.
- R6: While open, a key write of 0xFFFFFFFF seals the region on the edge that samples it. Every other key value, the key words included, leaves it open.
- R7: While sealed, a key write of 0xFFFFFFFF does nothing beyond discarding any progress, and the block stays sealed.
- R8: While sealed, `guard_rdata` is 0 and `guard_wr_out` is 0. While open, they follow `reg_rdata` and `guard_wr_in`.
- R9: A key write of 0x4F434B5F with no first word before it leaves the block sealed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr | input | 1 | Write strobe for the key register |
| key_data | input | 32 | Data of the key write |
| guard_wr_in | input | 1 | Write strobe for a guarded register, from the bus |
| guard_wr_out | output | 1 | Write strobe passed to the guarded registers |
| reg_rdata | input | 32 | Read data from the guarded registers |
| guard_rdata | output | 32 | Read data returned to the bus |
| unlocked | output | 1 | High while the region is open |

## Verification
A wrong state in the sequencer shows at the ports as `unlocked` holding the wrong value one edge after the key write that caused it. The gated strobe and the gated read data show the same error in the same cycle. A lost `ST_ARMED` state is hidden until the second key word arrives, so the key sequences put the second word at several distances from the first, with other traffic and wrong words in between. A spurious `ST_ARMED` state is caught by second words sent without a valid first word before them.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    typedef enum logic [1:0] {
        ST_SEALED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } lock_state_t;

    typedef enum logic [2:0] {
        KW_OTHER  = 3'd0,
        KW_FIRST  = 3'd1,
        KW_SECOND = 3'd2,
        KW_SEAL   = 3'd3,
        KW_CLEAR  = 3'd4
    } key_kind_t;

endpackage

// File: rtl/keylock_classify.sv
module keylock_classify
    import keylock_pkg::*;
#(
    parameter int              KEY_W      = 32,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 32'h5F55_4E4C,
    parameter logic [KEY_W-1:0] KEY_SECOND = 32'h4F43_4B5F
) (
    input  logic [KEY_W-1:0] data_i,
    output key_kind_t        kind_o
);
    localparam logic [KEY_W-1:0] KEY_SEAL  = '1;
    localparam logic [KEY_W-1:0] KEY_CLEAR = '0;

    always_comb begin
        if (data_i == KEY_FIRST)       kind_o = KW_FIRST;
        else if (data_i == KEY_SECOND) kind_o = KW_SECOND;
        else if (data_i == KEY_SEAL)   kind_o = KW_SEAL;
        else if (data_i == KEY_CLEAR)  kind_o = KW_CLEAR;
        else                           kind_o = KW_OTHER;
    end
endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
    import keylock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      key_wr_i,
    input  key_kind_t kind_i,
    output logic      open_o
);
    lock_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (key_wr_i) begin
            unique case (state_q)
                ST_SEALED: if (kind_i == KW_FIRST) state_d = ST_ARMED;
                ST_ARMED: begin
                    if (kind_i == KW_SECOND)     state_d = ST_OPEN;
                    else if (kind_i == KW_FIRST) state_d = ST_ARMED;
                    else                         state_d = ST_SEALED;
                end
                ST_OPEN:   if (kind_i == KW_SEAL) state_d = ST_SEALED;
                default:   state_d = ST_SEALED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEALED;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_OPEN: open_o = 1'b1;
            default: open_o = 1'b0;
        endcase
    end

    // Opening only ever follows a key write carrying the second word
    assert_open_needs_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(key_wr_i && kind_i == KW_SECOND));

    // A sealed block with no key write stays sealed
    assert_sealed_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && !key_wr_i) |=> !open_o);

    // All-ones key write seals an open block
    assert_seal_word_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && key_wr_i && kind_i == KW_SEAL) |=> !open_o);

    // Nothing but the seal word closes an open block
    assert_open_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && !(key_wr_i && kind_i == KW_SEAL)) |=> open_o);

    // An arming write is needed before the block can open
    assert_no_open_from_sealed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEALED) |=> !open_o);
endmodule

// File: rtl/keylock_gate.sv
module keylock_gate #(
    parameter int DATA_W = 32
) (
    input  logic              open_i,
    input  logic              wr_i,
    output logic              wr_o,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    assign wr_o    = wr_i & open_i;
    assign rdata_o = open_i ? rdata_i : '0;
endmodule

// File: rtl/register_key_guard.sv
module register_key_guard
    import keylock_pkg::*;
#(
    parameter int               KEY_W      = 32,
    parameter int               DATA_W     = 32,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 32'h5F55_4E4C,
    parameter logic [KEY_W-1:0] KEY_SECOND = 32'h4F43_4B5F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [KEY_W-1:0]  key_data,
    input  logic              guard_wr_in,
    output logic              guard_wr_out,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] guard_rdata,
    output logic              unlocked
);
    key_kind_t kind;
    logic      open;

    keylock_classify #(
        .KEY_W     (KEY_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_classify (
        .data_i(key_data),
        .kind_o(kind)
    );

    keylock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr_i(key_wr),
        .kind_i  (kind),
        .open_o  (open)
    );

    keylock_gate #(.DATA_W(DATA_W)) u_gate (
        .open_i (open),
        .wr_i   (guard_wr_in),
        .wr_o   (guard_wr_out),
        .rdata_i(reg_rdata),
        .rdata_o(guard_rdata)
    );

    assign unlocked = open;

    // While sealed, no write strobe reaches the guarded registers
    assert_sealed_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> (guard_wr_out == 1'b0 && guard_rdata == '0));
endmodule

// File: tb/tb_register_key_guard.sv
module tb_register_key_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr = 1'b0;
    logic [31:0] key_data = '0;
    logic        guard_wr_in = 1'b0;
    logic        guard_wr_out;
    logic [31:0] reg_rdata = '0;
    logic [31:0] guard_rdata;
    logic        unlocked;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    register_key_guard dut (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
        .guard_wr_in(guard_wr_in), .guard_wr_out(guard_wr_out),
        .reg_rdata(reg_rdata), .guard_rdata(guard_rdata), .unlocked(unlocked)
    );

    localparam logic [31:0] KA = 32'h5F55_4E4C;
    localparam logic [31:0] KB = 32'h4F43_4B5F;
    localparam logic [31:0] K1 = 32'hFFFF_FFFF;
    localparam logic [31:0] K0 = 32'h0000_0000;

    // {key write, key data, expected unlocked after the edge}
    localparam int NV = 25;
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, KA, 1'b0},           // 0  R2 first word
        {1'b1, KB, 1'b1},           // 1  R2 opens
        {1'b1, KA, 1'b1},           // 2  R6 ignored while open
        {1'b1, K0, 1'b1},           // 3  R6 ignored while open
        {1'b1, K1, 1'b0},           // 4  R6 seals
        {1'b1, K1, 1'b0},           // 5  R7 no effect sealed
        {1'b1, KB, 1'b0},           // 6  R9 lone second word
        {1'b1, KA, 1'b0},           // 7  R4
        {1'b1, K0, 1'b0},           // 8  R4 clear
        {1'b1, KB, 1'b0},           // 9  R4 must not open
        {1'b1, KA, 1'b0},           // 10 R3
        {1'b1, 32'h1234_5678, 1'b0},// 11 R3 wrong word
        {1'b1, KB, 1'b0},           // 12 R3 must not open
        {1'b1, KA, 1'b0},           // 13 R3
        {1'b1, KA, 1'b0},           // 14 R3 rearm
        {1'b1, KB, 1'b1},           // 15 R3 opens after rearm
        {1'b1, K1, 1'b0},           // 16 R6 seal
        {1'b1, KA, 1'b0},           // 17 R5
        {1'b0, K0, 1'b0},           // 18 R5 gap with guarded write
        {1'b0, K1, 1'b0},           // 19 R5 gap, data ignored
        {1'b1, KB, 1'b1},           // 20 R5 opens across the gap
        {1'b1, K1, 1'b0},           // 21 R6 seal
        {1'b1, KA, 1'b0},           // 22 R7
        {1'b1, K1, 1'b0},           // 23 R7 discards progress
        {1'b1, KB, 1'b0}            // 24 R7 stays sealed
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic key_step(input logic wr, input logic [31:0] d);
        key_wr   = wr;
        key_data = d;
        @(posedge clk);
        @(negedge clk);
        key_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({31'd0, unlocked}, 32'd0, "R1");

        for (int i = 0; i < NV; i++) begin
            guard_wr_in = (i == 18);
            key_step(VEC[i][33], VEC[i][32:1]);
            check({31'd0, unlocked}, {31'd0, VEC[i][0]}, $sformatf("R-vector %0d", i));
        end
        guard_wr_in = 1'b0;

        // R8 gating while sealed
        reg_rdata   = 32'hA5A5_1234;
        guard_wr_in = 1'b1;
        #1;
        check(guard_rdata, 32'd0, "R8 sealed read");
        check({31'd0, guard_wr_out}, 32'd0, "R8 sealed write");

        // R8 gating while open
        key_step(1'b1, KA);
        key_step(1'b1, KB);
        check(guard_rdata, 32'hA5A5_1234, "R8 open read");
        check({31'd0, guard_wr_out}, 32'd1, "R8 open write");
        guard_wr_in = 1'b0;
        #1;
        check({31'd0, guard_wr_out}, 32'd0, "R8 open no strobe");

        // R1 reset while open returns to sealed
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check({31'd0, unlocked}, 32'd0, "R1 reset while open");
        // R1 no partial progress survives reset
        key_step(1'b1, KA);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        key_step(1'b1, KB);
        check({31'd0, unlocked}, 32'd0, "R1 progress cleared by reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule